// File: doc/BRIEF.md
# Parallel Self-Synchronous Lane Descrambler

This block removes the multiplicative scrambling from one lane of a serial link. Each clock it takes one 16-bit word of scrambled payload and returns the plaintext word. The polynomial is 1 + x^14 + x^15. Every plaintext bit is the received bit XOR the received bits 14 and 15 positions earlier in the stream. The most significant bit of a word is the earliest bit in time. Bits early in a word therefore feed the later bits of the same word within the same cycle.

The only state is the last 15 received scrambled bits. No seed is needed. After one valid word the output is correct whatever the transmitter's scrambler held. A run-time bypass sends words through unchanged. The history keeps loading during bypass, so descrambling is correct from the first word after bypass is released. Both modes have one registered cycle of latency, and the valid strobe is delayed to match.

Top module: `lane_descrambler`

## Requirements
- R1: While and right after synchronous active-low reset, `out_vld` is 0 and `out_data` is 0, and the history holds all zeros.
- R2: `out_vld` equals the `in_vld` of the previous cycle.
- R3: With `bypass`=0, bit i of the output word is in_data[i] XOR the received scrambled bits 14 and 15 stream positions earlier. Bit 15 of a word is earliest in time, and the bit 0 of the previous word directly precedes the bit 15 of the next.
- R4: Bits of the same word feed later bits in that cycle: from a zero history, input 16'h8000 yields 16'h8003.
- R5: Cycles with `in_vld`=0 leave the history unchanged, whatever `in_data` holds.
- R6: With `bypass`=1, a valid word appears unchanged on `out_data` one cycle later.
- R7: The history loads every valid word while `bypass`=1, so the first word after bypass drops is descrambled against the bypassed data.
- R8: `out_data` holds its value in cycles after `in_vld`=0.
- R9: After one valid word, output equals the transmitter's plaintext for any transmitter seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bypass | input | 1 | 1 passes data unchanged, 0 descrambles |
| in_vld | input | 1 | Input word valid |
| in_data | input | 16 | Scrambled word, bit 15 earliest |
| out_vld | output | 1 | Output word valid, one cycle after input |
| out_data | output | 16 | Descrambled (or passed-through) word |

## Verification
Two functions can fall in the same cycle. One is the mode switch, which decides what reaches the output. The other is the history load, which always happens on a valid word. The bench toggles `bypass` on consecutive valid words, with idle cycles that carry junk data placed in between. A queue-based bit-stream model that loads in every mode then judges the first descrambled word after each switch, and each word, on every clock.

// File: rtl/lds_pkg.sv
// Package: default geometry shared by the descrambler modules.
// Assumes the far tap equals the history length (self-synchronous form).
package lds_pkg;
    localparam int DEF_DATA_W   = 16;
    localparam int DEF_TAP_NEAR = 14;
    localparam int DEF_TAP_FAR  = 15;
endpackage

// File: rtl/lds_unroll.sv
// Combinational unrolled descrambler. Joins the stored history (older bits)
// above the incoming word. Index k of the joined vector sits earlier in time
// as k grows. Each plaintext bit XORs its own bit with the bits TAP_NEAR and
// TAP_FAR places above it. Also yields the next history, the youngest
// TAP_FAR bits. Assumes TAP_NEAR < TAP_FAR.
module lds_unroll #(
    parameter int DATA_W   = lds_pkg::DEF_DATA_W,
    parameter int TAP_NEAR = lds_pkg::DEF_TAP_NEAR,
    parameter int TAP_FAR  = lds_pkg::DEF_TAP_FAR
) (
    input  logic [TAP_FAR-1:0] hist,
    input  logic [DATA_W-1:0]  din,
    output logic [DATA_W-1:0]  dplain,
    output logic [TAP_FAR-1:0] hist_next
);
    localparam int EXT_W = DATA_W + TAP_FAR;

    logic [EXT_W-1:0] ext;

    // Join history and word into one time-ordered vector.
    assign ext = {hist, din};

    // One XOR triple per output bit.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign dplain[i] = ext[i] ^ ext[i + TAP_NEAR] ^ ext[i + TAP_FAR];
    end

    // Youngest TAP_FAR received bits become the new history.
    assign hist_next = ext[TAP_FAR-1:0];
endmodule

// File: rtl/lds_history.sv
// History register: holds the last TAP_FAR scrambled bits received.
// Loads only when a valid word arrives, in either mode.
module lds_history #(
    parameter int TAP_FAR = lds_pkg::DEF_TAP_FAR
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [TAP_FAR-1:0] hist_next,
    output logic [TAP_FAR-1:0] hist
);
    // Capture the next history on valid words, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '0;
        else if (load)
            hist <= hist_next;
    end

    // R5: idle cycles leave the history untouched.
    a_r5_hist_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(hist));
endmodule

// File: rtl/lds_outreg.sv
// Output stage: registers either the plaintext or the raw word on valid
// input, holds the data otherwise, and delays valid by one cycle.
module lds_outreg #(
    parameter int DATA_W = lds_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              bypass,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] dplain,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data
);
    logic [DATA_W-1:0] sel;

    // Pick raw or descrambled word by mode.
    assign sel = bypass ? din : dplain;

    // Register data on valid words and track valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld)
                out_data <= sel;
        end
    end

    // R2: valid rises one cycle after input valid.
    a_r2_vld_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    // R2: no output valid without input valid the cycle before.
    a_r2_vld_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    // R8: data holds across idle cycles.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(out_data));
    // R6: bypassed words arrive unchanged.
    a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && bypass) |=> (out_data == $past(din)));
endmodule

// File: rtl/lane_descrambler.sv
// Top: one-lane self-synchronous descrambler, 1 + x^14 + x^15 by default.
// Word MSB is earliest in time. One-cycle registered latency in both modes.
module lane_descrambler #(
    parameter int DATA_W   = lds_pkg::DEF_DATA_W,
    parameter int TAP_NEAR = lds_pkg::DEF_TAP_NEAR,
    parameter int TAP_FAR  = lds_pkg::DEF_TAP_FAR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data
);
    logic [TAP_FAR-1:0] hist;
    logic [TAP_FAR-1:0] hist_next;
    logic [DATA_W-1:0]  dplain;

    lds_unroll #(.DATA_W(DATA_W), .TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)) u_unroll (
        .hist      (hist),
        .din       (in_data),
        .dplain    (dplain),
        .hist_next (hist_next)
    );

    lds_history #(.TAP_FAR(TAP_FAR)) u_history (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (in_vld),
        .hist_next (hist_next),
        .hist      (hist)
    );

    lds_outreg #(.DATA_W(DATA_W)) u_outreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .bypass   (bypass),
        .din      (in_data),
        .dplain   (dplain),
        .out_vld  (out_vld),
        .out_data (out_data)
    );
endmodule

// File: tb/lane_descrambler_bench.sv
// Bench: bit-queue reference model compared at every falling edge.
module lane_descrambler_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bypass = 1'b0;
    logic         in_vld = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         out_vld;
    logic [W-1:0] out_data;

    int checks = 0;
    int errors = 0;

    bit           rx_q[$];
    bit           tx_q[$];
    logic         exp_vld = 1'b0;
    logic [W-1:0] exp_data = '0;

    always #5 clk = ~clk;

    lane_descrambler u_lane_descrambler (
        .clk(clk), .rst_n(rst_n), .bypass(bypass), .in_vld(in_vld),
        .in_data(in_data), .out_vld(out_vld), .out_data(out_data)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Check outputs against expectation, then drive one cycle of input.
    task automatic step(input string tag, input logic v, input logic b, input logic [W-1:0] d);
        @(negedge clk);
        check({tag, " valid"}, W'(out_vld), W'(exp_vld));
        check({tag, " data"}, out_data, exp_data);
        in_vld = v; bypass = b; in_data = d;
        exp_vld = v;
        if (v) begin
            logic [W-1:0] plain;
            for (int i = W - 1; i >= 0; i--) begin
                plain[i] = d[i] ^ rx_q[rx_q.size() - 14] ^ rx_q[rx_q.size() - 15];
                rx_q.push_back(d[i]);
            end
            while (rx_q.size() > 40) void'(rx_q.pop_front());
            exp_data = b ? d : plain;
        end
    endtask

    // Transmit-side scrambler used for the self-sync check.
    function automatic logic [W-1:0] scramble(input logic [W-1:0] p);
        logic [W-1:0] s;
        for (int i = W - 1; i >= 0; i--) begin
            s[i] = p[i] ^ tx_q[tx_q.size() - 14] ^ tx_q[tx_q.size() - 15];
            tx_q.push_back(s[i]);
        end
        while (tx_q.size() > 40) void'(tx_q.pop_front());
        return s;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] plain_q[$];
        for (int i = 0; i < 15; i++) rx_q.push_back(1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid", W'(out_vld), '0);
        check("R1 reset data", out_data, '0);
        rst_n = 1'b1;

        // R4: single early bit feeds later bits of the same word.
        step("R1", 1'b1, 1'b0, 16'h8000);
        @(negedge clk);
        check("R4 intra-word", out_data, 16'h8003);
        // Resynchronise model step timing: this negedge already consumed.
        in_vld = 1'b0;
        exp_vld = 1'b0;

        // R3/R2: random descrambling stream.
        for (int n = 0; n < 40; n++) step("R3", 1'b1, 1'b0, W'($urandom));

        // R5/R8: idle cycles carrying junk, then valid words.
        for (int n = 0; n < 30; n++)
            step((n % 3 == 0) ? "R5" : "R8", (n % 3) == 2, 1'b0, W'($urandom));

        // R6/R7: bypass toggles on back-to-back valid words.
        for (int n = 0; n < 40; n++)
            step((n % 2) ? "R7" : "R6", 1'b1, ((n / 3) % 2) == 1, W'($urandom));
        for (int n = 0; n < 10; n++) step("R7", (n % 2) == 0, n < 5, W'($urandom));

        // R9: transmitter with a random seed; plaintext appears from word 2.
        for (int i = 0; i < 15; i++) tx_q.push_back(1'($urandom));
        for (int n = 0; n < 12; n++) begin
            logic [W-1:0] p;
            p = W'($urandom);
            plain_q.push_back(p);
            step("R9 stream", 1'b1, 1'b0, scramble(p));
            if (n >= 2) begin
                logic [W-1:0] prev;
                prev = plain_q[n - 1];
                check("R9 self-sync", out_data, prev);
            end
        end
        step("R2 drain", 1'b0, 1'b0, '0);
        step("R2 drain", 1'b0, 1'b0, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule